// File: doc/BRIEF.md
# Two-Stage Interrupt Priority Resolver

This block picks which of up to sixteen interrupt sources a processor should service next. It assembles a 16-bit pending vector from two software lines, six base hardware lines, four added hardware lines, a timer request and a performance-counter request. A timer-relocation control bit decides whether the timer shares base line 5 or gets its own pending bit. The pending vector is gated by two 8-bit enable words, one for sources 7:0 and one for sources 15:8. Only sources that are both pending and enabled take part in the decision.

Priority is not fixed in logic. A programmable 256-entry table maps an 8-bit pending pattern to a row number from 0 to 7. The table is consulted first with the low enabled byte. Only when that byte is all zero is it consulted with the high enabled byte, and then 8 is added to the row. As a result, every low-byte source outranks every high-byte source.

Alongside the chosen source index, the block emits a 16-bit service mask to hold while that source is serviced. The mask is a contiguous run of ones in bits 15:8, shaped by the row number and by the priority-direction input. All results are registered and appear one clock after the inputs are sampled. Software loads the table through a single address/data/write-enable port.

Top module: `irq_prio_resolver`

## Requirements
- R1: The pending vector places `sw_pend` at bits 1:0, `hw_pend` at bits 7:2, `ext_pend` at bits 11:8 and `perf_irq` at bit 13. Bits 15:14 are always zero.
- R2: With `timer_reloc` = 0, `timer_irq` is ORed into pending bit 7 and bit 12 stays zero. With `timer_reloc` = 1, `timer_irq` drives pending bit 12 and bit 7 carries `hw_pend[5]` alone.
- R3: A source takes part only if its enable bit is 1. `stat_mask[k]` enables pending bit k for k in 0..7, and `ext_mask[k]` enables pending bit 8+k.
- R4: When any enabled bit in 7:0 is set, `irq_src` = {1'b0, table[enabled bits 7:0]}.
- R5: When no enabled bit in 7:0 is set and some enabled bit in 15:8 is set, `irq_src` = {1'b1, table[enabled bits 15:8]}.
- R6: Any enabled low-byte source wins, regardless of which high-byte sources are also enabled and pending.
- R7: When no enabled source is pending, `irq_valid` = 0, `irq_src` = 0 and `irq_svc_mask` = 0. Otherwise `irq_valid` = 1.
- R8: With `msb_first` = 1 and table row r, `irq_svc_mask` has ones exactly in bits 8 through 8+r, giving 0x0100 for r = 0 up to 0xff00 for r = 7.
- R9: With `msb_first` = 0 and table row r, `irq_svc_mask` has ones exactly in bits 8+r through 15, giving 0xff00 for r = 0 down to 0x8000 for r = 7.
- R10: After reset, table entry a holds the position of the highest set bit of a, and entry 0 holds 0.
- R11: A cycle with `tbl_we` = 1 stores `tbl_row` at entry `tbl_addr`. Later lookups of that pattern return the stored row.
- R12: Outputs are registered. They reflect the inputs sampled at the previous rising clock edge and are all zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_pend | input | 2 | Software interrupt requests |
| hw_pend | input | 6 | Base hardware interrupt lines 0..5 |
| ext_pend | input | 4 | Added hardware interrupt lines |
| timer_irq | input | 1 | Timer request |
| perf_irq | input | 1 | Performance-counter request |
| timer_reloc | input | 1 | 1 moves the timer to its own pending bit |
| stat_mask | input | 8 | Enables for sources 7:0 |
| ext_mask | input | 8 | Enables for sources 15:8 |
| msb_first | input | 1 | Service-mask direction: 1 when the higher bit is the higher priority |
| tbl_we | input | 1 | Priority-table write enable |
| tbl_addr | input | 8 | Priority-table entry to write |
| tbl_row | input | 3 | Row value to write |
| irq_valid | output | 1 | An enabled source is pending |
| irq_src | output | 4 | Index of the winning source |
| irq_svc_mask | output | 16 | Mask to hold while servicing |

## Verification
The low byte is swept through all 256 patterns twice: once with the high byte idle, which isolates the first lookup, and once with every high source asserted, which shows that the first pass always wins. The high byte is swept through all 64 patterns it can reach with the timer relocated, which exercises the second lookup and the offset of 8. Both enable words are swept against fully pending inputs, and the timer is toggled in both relocation settings to show which pending bit it reaches. The whole table is then rewritten to a lowest-bit-wins order and both bytes are swept again in the other mask direction, which separates the reset contents from written contents and one mask shape from the other.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int LANE_W    = 8;
    localparam int PEND_W    = 2 * LANE_W;
    localparam int ROW_W     = $clog2(LANE_W);
    localparam int SRC_W     = ROW_W + 1;
    localparam int TBL_DEPTH = 1 << LANE_W;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [PEND_W-1:0] smask;
    } res_t;

    // Position of the highest set bit, zero for an empty pattern.
    function automatic row_t top_bit(input lane_t p);
        row_t r;
        r = '0;
        for (int i = 0; i < LANE_W; i++) begin
            if (p[i]) r = row_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irqp_pend_map.sv
module irqp_pend_map
    import irqp_pkg::*;
(
    input  logic [1:0]        sw_pend,
    input  logic [5:0]        hw_pend,
    input  logic [3:0]        ext_pend,
    input  logic              timer_irq,
    input  logic              perf_irq,
    input  logic              timer_reloc,
    input  logic [LANE_W-1:0] stat_mask,
    input  logic [LANE_W-1:0] ext_mask,
    output logic [PEND_W-1:0] eff_pend
);
    logic [PEND_W-1:0] raw;

    always_comb begin
        raw        = '0;
        raw[1:0]   = sw_pend;
        raw[6:2]   = hw_pend[4:0];
        raw[7]     = hw_pend[5] | (timer_irq & ~timer_reloc);   // R2 shared line
        raw[11:8]  = ext_pend;
        raw[12]    = timer_irq & timer_reloc;                   // R2 own bit
        raw[13]    = perf_irq;                                  // R1, bits 15:14 stay 0
        eff_pend   = raw & {ext_mask, stat_mask};               // R3
    end
endmodule

// File: rtl/irqp_prio_table.sv
module irqp_prio_table
    import irqp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] wr_addr,
    input  row_t              wr_row,
    input  logic [LANE_W-1:0] rd_addr,
    output row_t              rd_row
);
    row_t mem_q [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < TBL_DEPTH; a++) begin
                mem_q[a] <= top_bit(lane_t'(a));                // R10
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_row;                           // R11
        end
    end

    assign rd_row = mem_q[rd_addr];

    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_row)));
endmodule

// File: rtl/irqp_mask_gen.sv
module irqp_mask_gen
    import irqp_pkg::*;
(
    input  row_t              row,
    input  logic              msb_first,
    output logic [PEND_W-1:0] svc_mask
);
    always_comb begin
        svc_mask = '0;
        for (int i = 0; i < LANE_W; i++) begin
            if (msb_first) svc_mask[LANE_W+i] = (i <= int'(row));   // R8
            else           svc_mask[LANE_W+i] = (i >= int'(row));   // R9
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irqp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  sw_pend,
    input  logic [5:0]  hw_pend,
    input  logic [3:0]  ext_pend,
    input  logic        timer_irq,
    input  logic        perf_irq,
    input  logic        timer_reloc,
    input  logic [7:0]  stat_mask,
    input  logic [7:0]  ext_mask,
    input  logic        msb_first,
    input  logic        tbl_we,
    input  logic [7:0]  tbl_addr,
    input  logic [2:0]  tbl_row,
    output logic        irq_valid,
    output logic [3:0]  irq_src,
    output logic [15:0] irq_svc_mask
);
    logic [PEND_W-1:0] eff;
    logic              low_any, high_any;
    lane_t             lk_addr;
    row_t              lk_row;
    logic [PEND_W-1:0] lk_mask;
    res_t              res_d, res_q;

    irqp_pend_map u_map (
        .sw_pend    (sw_pend),
        .hw_pend    (hw_pend),
        .ext_pend   (ext_pend),
        .timer_irq  (timer_irq),
        .perf_irq   (perf_irq),
        .timer_reloc(timer_reloc),
        .stat_mask  (stat_mask),
        .ext_mask   (ext_mask),
        .eff_pend   (eff)
    );

    // One shared read port: the second pass reuses the same entries.
    assign low_any  = |eff[LANE_W-1:0];
    assign high_any = |eff[PEND_W-1:LANE_W];
    assign lk_addr  = low_any ? eff[LANE_W-1:0] : eff[PEND_W-1:LANE_W];

    irqp_prio_table u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_addr(tbl_addr),
        .wr_row (tbl_row),
        .rd_addr(lk_addr),
        .rd_row (lk_row)
    );

    irqp_mask_gen u_mask (
        .row      (lk_row),
        .msb_first(msb_first),
        .svc_mask (lk_mask)
    );

    always_comb begin
        res_d = '0;                                            // R7
        if (low_any || high_any) begin
            res_d.valid = 1'b1;
            res_d.src   = {~low_any, lk_row};                  // R4 R5 R6
            res_d.smask = lk_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;                               // R12
        else        res_q <= res_d;
    end

    assign irq_valid    = res_q.valid;
    assign irq_src      = res_q.src;
    assign irq_svc_mask = res_q.smask;

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_src == '0 && irq_svc_mask == '0));

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_valid == $past(|eff)));

    a_r6_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|eff[LANE_W-1:0]) |=> (irq_valid && !irq_src[SRC_W-1]));

    a_r5_second_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (eff[LANE_W-1:0] == '0 && |eff[PEND_W-1:LANE_W]) |=> (irq_valid && irq_src[SRC_W-1]));

    a_r8_mask_anchor: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_svc_mask[LANE_W-1:0] == '0 &&
                       (irq_svc_mask[LANE_W] || irq_svc_mask[PEND_W-1])));
endmodule

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  sw_pend;
    logic [5:0]  hw_pend;
    logic [3:0]  ext_pend;
    logic        timer_irq, perf_irq, timer_reloc, msb_first, tbl_we;
    logic [7:0]  stat_mask, ext_mask, tbl_addr;
    logic [2:0]  tbl_row;
    logic        irq_valid;
    logic [3:0]  irq_src;
    logic [15:0] irq_svc_mask;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] mdl [256];

    always #2.5 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .sw_pend(sw_pend), .hw_pend(hw_pend),
        .ext_pend(ext_pend), .timer_irq(timer_irq), .perf_irq(perf_irq),
        .timer_reloc(timer_reloc), .stat_mask(stat_mask), .ext_mask(ext_mask),
        .msb_first(msb_first), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_row(tbl_row), .irq_valid(irq_valid), .irq_src(irq_src),
        .irq_svc_mask(irq_svc_mask)
    );

    function automatic logic [2:0] hi_bit(input logic [7:0] p);
        logic [2:0] r = 3'd0;
        for (int i = 0; i < 8; i++) if (p[i]) r = 3'(i);
        return r;
    endfunction

    function automatic logic [2:0] lo_bit(input logic [7:0] p);
        logic [2:0] r = 3'd0;
        for (int i = 7; i >= 0; i--) if (p[i]) r = 3'(i);
        return r;
    endfunction

    // Expected {valid, src, mask} computed from the requirements.
    function automatic logic [20:0] expect_out();
        logic [15:0] pend, eff, m;
        logic [2:0]  r;
        logic        hi;
        pend = '0;
        pend[1:0]  = sw_pend;
        pend[6:2]  = hw_pend[4:0];
        pend[7]    = hw_pend[5] | (timer_irq & ~timer_reloc);
        pend[11:8] = ext_pend;
        pend[12]   = timer_irq & timer_reloc;
        pend[13]   = perf_irq;
        eff = pend & {ext_mask, stat_mask};
        if (eff == 16'h0) return 21'h0;
        hi = (eff[7:0] == 8'h0);
        r  = hi ? mdl[eff[15:8]] : mdl[eff[7:0]];
        m  = '0;
        for (int i = 0; i < 8; i++)
            m[8+i] = msb_first ? (i <= int'(r)) : (i >= int'(r));
        return {1'b1, hi, r, m};
    endfunction

    task automatic step_check(input string tag);
        logic [20:0] exp_v;
        exp_v = expect_out();
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if ({irq_valid, irq_src, irq_svc_mask} !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got v=%0b src=%0d mask=%h, expected v=%0b src=%0d mask=%h",
                     tag, irq_valid, irq_src, irq_svc_mask, exp_v[20], exp_v[19:16], exp_v[15:0]);
        end
    endtask

    task automatic set_low(input logic [7:0] p);
        sw_pend = p[1:0];
        hw_pend = p[7:2];
    endtask

    task automatic set_high(input logic [5:0] p);
        ext_pend  = p[3:0];
        timer_irq = p[4];
        perf_irq  = p[5];
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mdl[a] = hi_bit(8'(a));   // R10 reset contents
        rst_n = 1'b0; sw_pend = '0; hw_pend = '0; ext_pend = '0;
        timer_irq = 0; perf_irq = 0; timer_reloc = 0; msb_first = 1;
        tbl_we = 0; tbl_addr = '0; tbl_row = '0;
        stat_mask = 8'hff; ext_mask = 8'hff;
        set_low(8'hff);
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;                                               // R12 reset state
        if ({irq_valid, irq_src, irq_svc_mask} !== 21'h0) begin
            n_bad++;
            $display("FAIL R12 reset: got %h, expected 0", {irq_valid, irq_src, irq_svc_mask});
        end
        rst_n = 1'b1;
        set_low(8'h00);
        step_check("R7 idle");

        // R4 R10 R8 R1: low byte alone, default table, MSB-first masks
        for (int p = 0; p < 256; p++) begin
            set_low(8'(p));
            step_check("R4/R10/R8 low sweep");
        end
        // R6: low byte against every high source
        timer_reloc = 1;
        for (int p = 1; p < 256; p++) begin
            set_low(8'(p)); set_high(6'h3f);
            step_check("R6 low beats high");
        end
        // R5 R1 R2: high byte alone with relocated timer
        set_low(8'h00);
        for (int p = 0; p < 64; p++) begin
            set_high(6'(p));
            step_check("R5/R1/R2 high sweep");
        end
        // R2: timer on the shared line
        timer_reloc = 0; set_high(6'h10);
        step_check("R2 timer shared");
        hw_pend = 6'h20;
        step_check("R2 timer plus line 5");
        hw_pend = 6'h00; timer_reloc = 1;
        step_check("R2 timer relocated");
        // R3: enable words
        set_high(6'h00);
        for (int m = 0; m < 256; m++) begin
            set_low(8'hff); stat_mask = 8'(m);
            step_check("R3 low enables");
        end
        stat_mask = 8'h00; set_low(8'hff); set_high(6'h3f);
        for (int m = 0; m < 256; m++) begin
            ext_mask = 8'(m);
            step_check("R3 high enables");
        end
        stat_mask = 8'hff; ext_mask = 8'hff;

        // R11: rewrite the table to lowest-bit-wins
        set_low(8'h00); set_high(6'h00);
        for (int a = 0; a < 256; a++) begin
            tbl_we = 1; tbl_addr = 8'(a); tbl_row = lo_bit(8'(a));
            mdl[a] = lo_bit(8'(a));
            @(posedge clk);
            @(negedge clk);
        end
        tbl_we = 0;
        msb_first = 0;
        for (int p = 0; p < 256; p++) begin
            set_low(8'(p));
            step_check("R11/R9 low sweep");
        end
        set_low(8'h00);
        for (int p = 0; p < 64; p++) begin
            set_high(6'(p));
            step_check("R11/R9/R5 high sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule